// File: doc/BRIEF.md
# Location-Tracking Translation Lookup Router

This block is a set-associative translation buffer in which every page entry carries a small location table as well as its virtual tag, physical page number and access permissions. The location table has one short record per cache line of the page. Each record says where that line currently lives: nowhere in the caches, the instruction L1, the data L1, or the L2. It also gives the way the line occupies there.

A core request presents a virtual address. The block selects the one record for the addressed line and turns it straight into a single downstream action. That action is one of four:
- a direct L1 read of a named set and way;
- a direct L2 read whose set index is composed from virtual line bits and low physical page bits;
- a memory request that carries the physical line address;
- a miss report for the separate fill controller.

No tag comparison against a data cache is ever made.

The fill and eviction logic keeps the tables current through an update port. That port can install a page, rewrite one line record, load the table of a region together with the region's valid bit, or clear a region's valid bit. Each page is divided into equal regions, and each region has its own valid bit. Four regions of 16 lines each is the micro-page arrangement. A single region gives one valid bit per page.

Top module: `ltlb_router`

## Requirements
- R1: After reset, rspValid is 0, reqReady is 1, and no page is present, so the first lookup reports a miss.
- R2: A request is accepted on a clock edge where reqValid and reqReady are both 1. reqReady is 0 whenever updValid is 1. The response is registered on the accepting edge and is valid for exactly one cycle. rspKind is one-hot: bit0 = L1 read, bit1 = L2 read, bit2 = memory request, bit3 = miss.
- R3: A hit whose record level code is 01 (L1 instruction) or 10 (L1 data) gives an L1 read. Its index is VA[10:6], zero-extended. Its way is the record's 4-bit way. rspL1Instr is 1 exactly for code 01.
- R4: A hit whose level code is 11 gives an L2 read. Its index is {PPN[3:0], VA[11:6]}, and its way is the record's way.
- R5: A hit whose level code is 00 gives a memory request with rspAddr = {PPN, VA[11:6], 6'b0}. Its way and index are 0.
- R6: A lookup whose page matches no valid entry of its set (set = VA[14:12], tag = VA[31:15]) is a miss. A miss returns rspAddr = VA and rspPerm = 0. It also returns the fill way: the lowest-numbered free way of the set, or else the least recently used way.
- R7: A lookup whose page is present but whose region valid bit (region = VA[11:10]) is clear is a miss. Its rspWay is the way that holds the page.
- R8: updOp 1 rewrites only the 6-bit record of line updLineVa[5:0] in entry {set, updWay}. The record value is updData[5:0], laid out as {level[1:0], way[3:0]}. All other records are unchanged.
- R9: updOp 2 writes the 16 records of one region from updData (line j of the region at bits 6j+5:6j) and sets that region's valid bit. updOp 3 clears one region's valid bit and leaves the other regions of the page usable.
- R10: A hit and an install (updOp 0) each make their way the most recently used way of the set. With all ways of a set valid, the miss fill way is the least recently used way.
- R11: Every hit returns the permissions stored when the page was installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request valid |
| reqReady | output | 1 | Lookup request can be accepted |
| reqVa | input | 32 | Virtual address of the lookup |
| updValid | input | 1 | Update command valid (takes priority over lookups) |
| updOp | input | 2 | 0 install page, 1 write line record, 2 load region table, 3 clear region valid |
| updLineVa | input | 26 | Virtual line address VA[31:6] that selects the set, tag, line and region |
| updWay | input | 3 | Buffer way to write |
| updPpn | input | 20 | Physical page number for an install |
| updPerm | input | 3 | Permissions for an install |
| updData | input | 96 | Region table, or one record in bits 5:0 |
| rspValid | output | 1 | Response valid for one cycle |
| rspKind | output | 4 | One-hot action: L1, L2, memory, miss |
| rspL1Instr | output | 1 | L1 read targets the instruction cache |
| rspIndex | output | 10 | L1 or L2 set index |
| rspWay | output | 4 | Cache way, or buffer fill way on a miss |
| rspAddr | output | 32 | Physical line address (memory) or virtual address (miss) |
| rspPerm | output | 3 | Page permissions on a hit |

## Verification
Every lookup result is due on the edge that accepts the request. The bench drives the request at a falling edge. It reads all response fields at the next falling edge, which is half a cycle after the accepting edge. It reads rspValid once more a full cycle later to confirm that the response has dropped. Update commands take effect on the single rising edge they are held across. Follow-up lookups therefore start only after updValid has been released, and the bench samples reqReady just after raising updValid.

// File: rtl/ltlb_pkg.sv
package ltlb_pkg;

  typedef enum logic [1:0] {
    LVL_NONE = 2'b00,
    LVL_L1I  = 2'b01,
    LVL_L1D  = 2'b10,
    LVL_L2   = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    UPD_INSTALL = 2'd0,
    UPD_LINE    = 2'd1,
    UPD_TABLE   = 2'd2,
    UPD_DROP    = 2'd3
  } upd_e;

  localparam int KIND_L1   = 0;
  localparam int KIND_L2   = 1;
  localparam int KIND_DRAM = 2;
  localparam int KIND_MISS = 3;
  localparam int KIND_W    = 4;

  // strobes from control to the storage datapath
  typedef struct packed {
    logic touchHit;
    logic wrInstall;
    logic wrLine;
    logic wrTable;
    logic wrDrop;
  } ctl_t;

endpackage

// File: rtl/ltlb_store.sv
module ltlb_store
  import ltlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PPN_W     = 20,
  parameter int PERM_W    = 3,
  parameter int ENTRIES   = 64,
  parameter int WAYS      = 8,
  parameter int REGIONS   = 4,
  parameter int PAGE_W    = 12,
  parameter int LINE_W    = 6,
  parameter int LOC_WAY_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctl_t                      ctl,
  input  logic [VA_W-1:LINE_W]      lookLva,
  input  logic [VA_W-1:LINE_W]      updLva,
  input  logic [$clog2(WAYS)-1:0]   updWay,
  input  logic [PPN_W-1:0]          updPpn,
  input  logic [PERM_W-1:0]         updPerm,
  input  logic [((1<<(PAGE_W-LINE_W))/REGIONS)*(2+LOC_WAY_W)-1:0] updData,
  output logic                      lookHit,
  output logic                      lookPresent,
  output logic [$clog2(WAYS)-1:0]   lookWay,
  output logic [$clog2(WAYS)-1:0]   lookVictim,
  output logic [1+LOC_WAY_W:0]      lookLoc,
  output logic [PPN_W-1:0]          lookPpn,
  output logic [PERM_W-1:0]         lookPerm
);

  localparam int SETS    = ENTRIES / WAYS;
  localparam int SET_W   = $clog2(SETS);
  localparam int TWAY_W  = $clog2(WAYS);
  localparam int ENT_W   = SET_W + TWAY_W;
  localparam int LIDX_W  = PAGE_W - LINE_W;
  localparam int LINES   = 1 << LIDX_W;
  localparam int LOC_W   = 2 + LOC_WAY_W;
  localparam int RLINES  = LINES / REGIONS;
  localparam int RDATA_W = RLINES * LOC_W;
  localparam int RIDX_W  = (REGIONS > 1) ? $clog2(REGIONS) : 1;
  localparam int TAG_W   = VA_W - PAGE_W - SET_W;

  // entry storage
  logic                     pageValid [ENTRIES];
  logic [REGIONS-1:0]       rgnValid  [ENTRIES];
  logic [TAG_W-1:0]         tagMem    [ENTRIES];
  logic [PPN_W-1:0]         ppnMem    [ENTRIES];
  logic [PERM_W-1:0]        permMem   [ENTRIES];
  logic [LINES*LOC_W-1:0]   locMem    [ENTRIES];
  logic [TWAY_W-1:0]        age       [SETS][WAYS];

  // lookup address fields
  logic [SET_W-1:0]  lookSet;
  logic [TAG_W-1:0]  lookTag;
  logic [LIDX_W-1:0] lookLine;
  logic [RIDX_W-1:0] lookRgn;
  logic [ENT_W-1:0]  lookEnt;

  assign lookSet  = lookLva[PAGE_W +: SET_W];
  assign lookTag  = lookLva[VA_W-1 -: TAG_W];
  assign lookLine = lookLva[LINE_W +: LIDX_W];
  assign lookRgn  = RIDX_W'(int'(lookLine) / RLINES);

  // update address fields
  logic [SET_W-1:0]  updSet;
  logic [TAG_W-1:0]  updTag;
  logic [LIDX_W-1:0] updLine;
  logic [RIDX_W-1:0] updRgn;
  logic [ENT_W-1:0]  updEnt;

  assign updSet  = updLva[PAGE_W +: SET_W];
  assign updTag  = updLva[VA_W-1 -: TAG_W];
  assign updLine = updLva[LINE_W +: LIDX_W];
  assign updRgn  = RIDX_W'(int'(updLine) / RLINES);
  assign updEnt  = {updSet, updWay};

  // per-way tag match and free detection
  logic [WAYS-1:0] wayMatch;
  logic [WAYS-1:0] wayFree;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wayMatch[w] = pageValid[{lookSet, TWAY_W'(w)}] &&
                         (tagMem[{lookSet, TWAY_W'(w)}] == lookTag);
    assign wayFree[w]  = !pageValid[{lookSet, TWAY_W'(w)}];
  end

  always_comb begin
    lookWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayMatch[w]) lookWay = TWAY_W'(w);
    end
  end

  // fill way: lowest free way, otherwise the oldest way
  always_comb begin
    lookVictim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age[lookSet][w] == TWAY_W'(WAYS - 1)) lookVictim = TWAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayFree[w]) lookVictim = TWAY_W'(w);
    end
  end

  assign lookEnt     = {lookSet, lookWay};
  assign lookPresent = |wayMatch;
  assign lookHit     = lookPresent && rgnValid[lookEnt][lookRgn];
  assign lookLoc     = locMem[lookEnt][int'(lookLine)*LOC_W +: LOC_W];
  assign lookPpn     = ppnMem[lookEnt];
  assign lookPerm    = permMem[lookEnt];

  // recency update source
  logic              touchEn;
  logic [SET_W-1:0]  touchSet;
  logic [TWAY_W-1:0] touchWay;

  assign touchEn  = ctl.touchHit || ctl.wrInstall;
  assign touchSet = ctl.wrInstall ? updSet : lookSet;
  assign touchWay = ctl.wrInstall ? updWay : lookWay;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        pageValid[e] <= 1'b0;
        rgnValid[e]  <= '0;
      end
      for (int s = 0; s < SETS; s++) begin
        for (int v = 0; v < WAYS; v++) begin
          age[s][v] <= TWAY_W'(v);
        end
      end
    end else begin
      if (ctl.wrInstall) begin
        pageValid[updEnt] <= 1'b1;
        rgnValid[updEnt]  <= '0;
      end
      if (ctl.wrTable) rgnValid[updEnt][updRgn] <= 1'b1;
      if (ctl.wrDrop)  rgnValid[updEnt][updRgn] <= 1'b0;
      if (touchEn) begin
        for (int v = 0; v < WAYS; v++) begin
          if (TWAY_W'(v) == touchWay) begin
            age[touchSet][v] <= '0;
          end else if (age[touchSet][v] < age[touchSet][touchWay]) begin
            age[touchSet][v] <= age[touchSet][v] + TWAY_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.wrInstall) begin
      tagMem[updEnt]  <= updTag;
      ppnMem[updEnt]  <= updPpn;
      permMem[updEnt] <= updPerm;
    end
    if (ctl.wrLine) begin
      locMem[updEnt][int'(updLine)*LOC_W +: LOC_W] <= updData[LOC_W-1:0];
    end
    if (ctl.wrTable) begin
      locMem[updEnt][int'(updRgn)*RDATA_W +: RDATA_W] <= updData;
    end
  end

  // R2: control never raises two storage strobes together
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ctl) <= 1);

  // R10: a hit leaves its way the youngest of its set
  a_r10_touch_youngest: assert property (@(posedge clk) disable iff (!rstN)
    ctl.touchHit |=> age[$past(lookSet)][$past(lookWay)] == '0);

  // R6: a free way, when one exists, is the one chosen for a fill
  a_r6_victim_free: assert property (@(posedge clk) disable iff (!rstN)
    (|wayFree) |-> !pageValid[{lookSet, lookVictim}]);

  // R10: with a full set the fill way is the oldest
  a_r10_victim_oldest: assert property (@(posedge clk) disable iff (!rstN)
    !(|wayFree) |-> age[lookSet][lookVictim] == TWAY_W'(WAYS - 1));

endmodule

// File: rtl/ltlb_ctrl.sv
module ltlb_ctrl
  import ltlb_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PPN_W       = 20,
  parameter int PERM_W      = 3,
  parameter int WAYS        = 8,
  parameter int PAGE_W      = 12,
  parameter int LINE_W      = 6,
  parameter int LOC_WAY_W   = 4,
  parameter int L1_SET_W    = 5,
  parameter int L2_PPN_BITS = 4,
  parameter int IDX_W       = 10,
  parameter int ADDR_W      = 32,
  parameter int RWAY_W      = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [VA_W-1:0]         reqVa,
  output logic                    reqReady,
  input  logic                    updValid,
  input  logic [1:0]              updOp,
  output ctl_t                    ctl,
  input  logic                    lookHit,
  input  logic                    lookPresent,
  input  logic [$clog2(WAYS)-1:0] lookWay,
  input  logic [$clog2(WAYS)-1:0] lookVictim,
  input  logic [1+LOC_WAY_W:0]    lookLoc,
  input  logic [PPN_W-1:0]        lookPpn,
  input  logic [PERM_W-1:0]       lookPerm,
  output logic                    rspValid,
  output logic [KIND_W-1:0]       rspKind,
  output logic                    rspL1Instr,
  output logic [IDX_W-1:0]        rspIndex,
  output logic [RWAY_W-1:0]       rspWay,
  output logic [ADDR_W-1:0]       rspAddr,
  output logic [PERM_W-1:0]       rspPerm
);

  localparam int LIDX_W = PAGE_W - LINE_W;
  localparam int LOC_W  = 2 + LOC_WAY_W;

  logic accept;
  assign reqReady = !updValid;
  assign accept   = reqValid && reqReady;

  assign ctl.touchHit  = accept && lookHit;
  assign ctl.wrInstall = updValid && (upd_e'(updOp) == UPD_INSTALL);
  assign ctl.wrLine    = updValid && (upd_e'(updOp) == UPD_LINE);
  assign ctl.wrTable   = updValid && (upd_e'(updOp) == UPD_TABLE);
  assign ctl.wrDrop    = updValid && (upd_e'(updOp) == UPD_DROP);

  lvl_e                 lvl;
  logic [LOC_WAY_W-1:0] locWay;
  assign lvl    = lvl_e'(lookLoc[LOC_W-1 -: 2]);
  assign locWay = lookLoc[LOC_WAY_W-1:0];

  logic [KIND_W-1:0] nKind;
  logic              nL1I;
  logic [IDX_W-1:0]  nIdx;
  logic [RWAY_W-1:0] nWay;
  logic [ADDR_W-1:0] nAddr;
  logic [PERM_W-1:0] nPerm;

  always_comb begin
    nKind = '0;
    nL1I  = 1'b0;
    nIdx  = '0;
    nWay  = '0;
    nAddr = '0;
    nPerm = '0;
    if (!lookHit) begin
      nKind[KIND_MISS] = 1'b1;
      nAddr = ADDR_W'(reqVa);
      nWay  = RWAY_W'(lookPresent ? lookWay : lookVictim);
    end else begin
      nPerm = lookPerm;
      unique case (lvl)
        LVL_NONE: begin
          nKind[KIND_DRAM] = 1'b1;
          nAddr = ADDR_W'({lookPpn, reqVa[PAGE_W-1:LINE_W], LINE_W'(0)});
        end
        LVL_L1I, LVL_L1D: begin
          nKind[KIND_L1] = 1'b1;
          nL1I = (lvl == LVL_L1I);
          nIdx = IDX_W'(reqVa[LINE_W +: L1_SET_W]);
          nWay = RWAY_W'(locWay);
        end
        default: begin
          nKind[KIND_L2] = 1'b1;
          nIdx = IDX_W'({lookPpn[L2_PPN_BITS-1:0], reqVa[PAGE_W-1:LINE_W]});
          nWay = RWAY_W'(locWay);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspKind    <= '0;
      rspL1Instr <= 1'b0;
      rspIndex   <= '0;
      rspWay     <= '0;
      rspAddr    <= '0;
      rspPerm    <= '0;
    end else begin
      rspValid   <= accept;
      rspKind    <= accept ? nKind : '0;
      rspL1Instr <= accept && nL1I;
      rspIndex   <= accept ? nIdx  : '0;
      rspWay     <= accept ? nWay  : '0;
      rspAddr    <= accept ? nAddr : '0;
      rspPerm    <= accept ? nPerm : '0;
    end
  end

  // R2: exactly one action per response
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones(rspKind) == 1);

  // R2: no action outside a response
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> rspKind == '0);

  // R2: a response only follows an accepted request
  a_r2_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady));

  // R4: L2 index low part is the requested line
  a_r4_l2_line: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind[KIND_L2]) |->
      rspIndex[LIDX_W-1:0] == $past(reqVa[PAGE_W-1:LINE_W]));

  // R6: a miss reports the virtual address it was asked for
  a_r6_miss_addr: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind[KIND_MISS]) |-> rspAddr == ADDR_W'($past(reqVa)));

endmodule

// File: rtl/ltlb_router.sv
module ltlb_router
  import ltlb_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PPN_W       = 20,
  parameter int PERM_W      = 3,
  parameter int ENTRIES     = 64,
  parameter int WAYS        = 8,
  parameter int REGIONS     = 4,
  parameter int PAGE_W      = 12,
  parameter int LINE_W      = 6,
  parameter int LOC_WAY_W   = 4,
  parameter int L1_SET_W    = 5,
  parameter int L2_PPN_BITS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic [VA_W-1:0]              reqVa,
  input  logic                         updValid,
  input  logic [1:0]                   updOp,
  input  logic [VA_W-LINE_W-1:0]       updLineVa,
  input  logic [$clog2(WAYS)-1:0]      updWay,
  input  logic [PPN_W-1:0]             updPpn,
  input  logic [PERM_W-1:0]            updPerm,
  input  logic [((1<<(PAGE_W-LINE_W))/REGIONS)*(2+LOC_WAY_W)-1:0] updData,
  output logic                         rspValid,
  output logic [KIND_W-1:0]            rspKind,
  output logic                         rspL1Instr,
  output logic [((L1_SET_W > PAGE_W-LINE_W+L2_PPN_BITS) ? L1_SET_W : PAGE_W-LINE_W+L2_PPN_BITS)-1:0] rspIndex,
  output logic [((LOC_WAY_W > $clog2(WAYS)) ? LOC_WAY_W : $clog2(WAYS))-1:0] rspWay,
  output logic [((VA_W > PPN_W+PAGE_W) ? VA_W : PPN_W+PAGE_W)-1:0] rspAddr,
  output logic [PERM_W-1:0]            rspPerm
);

  localparam int TWAY_W   = $clog2(WAYS);
  localparam int L2_SET_W = PAGE_W - LINE_W + L2_PPN_BITS;
  localparam int IDX_W    = (L1_SET_W > L2_SET_W) ? L1_SET_W : L2_SET_W;
  localparam int RWAY_W   = (LOC_WAY_W > TWAY_W) ? LOC_WAY_W : TWAY_W;
  localparam int ADDR_W   = (VA_W > PPN_W + PAGE_W) ? VA_W : PPN_W + PAGE_W;

  ctl_t                 ctl;
  logic                 lookHit;
  logic                 lookPresent;
  logic [TWAY_W-1:0]    lookWay;
  logic [TWAY_W-1:0]    lookVictim;
  logic [1+LOC_WAY_W:0] lookLoc;
  logic [PPN_W-1:0]     lookPpn;
  logic [PERM_W-1:0]    lookPerm;

  ltlb_store #(
    .VA_W(VA_W), .PPN_W(PPN_W), .PERM_W(PERM_W), .ENTRIES(ENTRIES),
    .WAYS(WAYS), .REGIONS(REGIONS), .PAGE_W(PAGE_W), .LINE_W(LINE_W),
    .LOC_WAY_W(LOC_WAY_W)
  ) uStore (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .lookLva(reqVa[VA_W-1:LINE_W]), .updLva(updLineVa),
    .updWay(updWay), .updPpn(updPpn), .updPerm(updPerm), .updData(updData),
    .lookHit(lookHit), .lookPresent(lookPresent), .lookWay(lookWay),
    .lookVictim(lookVictim), .lookLoc(lookLoc), .lookPpn(lookPpn),
    .lookPerm(lookPerm)
  );

  ltlb_ctrl #(
    .VA_W(VA_W), .PPN_W(PPN_W), .PERM_W(PERM_W), .WAYS(WAYS),
    .PAGE_W(PAGE_W), .LINE_W(LINE_W), .LOC_WAY_W(LOC_WAY_W),
    .L1_SET_W(L1_SET_W), .L2_PPN_BITS(L2_PPN_BITS), .IDX_W(IDX_W),
    .ADDR_W(ADDR_W), .RWAY_W(RWAY_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa),
    .reqReady(reqReady), .updValid(updValid), .updOp(updOp), .ctl(ctl),
    .lookHit(lookHit), .lookPresent(lookPresent), .lookWay(lookWay),
    .lookVictim(lookVictim), .lookLoc(lookLoc), .lookPpn(lookPpn),
    .lookPerm(lookPerm), .rspValid(rspValid), .rspKind(rspKind),
    .rspL1Instr(rspL1Instr), .rspIndex(rspIndex), .rspWay(rspWay),
    .rspAddr(rspAddr), .rspPerm(rspPerm)
  );

endmodule

// File: tb/ltlb_router_test.sv
module ltlb_router_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVa = '0;
  logic        updValid = 1'b0;
  logic [1:0]  updOp = '0;
  logic [25:0] updLineVa = '0;
  logic [2:0]  updWay = '0;
  logic [19:0] updPpn = '0;
  logic [2:0]  updPerm = '0;
  logic [95:0] updData = '0;
  logic        rspValid;
  logic [3:0]  rspKind;
  logic        rspL1Instr;
  logic [9:0]  rspIndex;
  logic [3:0]  rspWay;
  logic [31:0] rspAddr;
  logic [2:0]  rspPerm;

  ltlb_router uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .updValid(updValid), .updOp(updOp), .updLineVa(updLineVa),
    .updWay(updWay), .updPpn(updPpn), .updPerm(updPerm), .updData(updData),
    .rspValid(rspValid), .rspKind(rspKind), .rspL1Instr(rspL1Instr),
    .rspIndex(rspIndex), .rspWay(rspWay), .rspAddr(rspAddr), .rspPerm(rspPerm)
  );

  always #4 clk = ~clk;

  localparam logic [3:0] K_L1 = 4'b0001, K_L2 = 4'b0010,
                         K_MEM = 4'b0100, K_MISS = 4'b1000;
  localparam logic [19:0] PPN_A  = 20'hABCD3;
  localparam logic [2:0]  PERM_A = 3'b101;

  // {line, expected kind}
  localparam logic [9:0] VEC [8] = '{
    {6'd0,  K_MEM}, {6'd1,  K_L1}, {6'd2,  K_L1}, {6'd3,  K_L2},
    {6'd17, K_L1},  {6'd46, K_L1}, {6'd63, K_L2}, {6'd32, K_MEM}
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [5:0] model [64];

  function automatic logic [5:0] locOf(int i);
    return {2'(i % 4), 4'((i * 7 + 1) % 16)};
  endfunction

  function automatic logic [95:0] rgnData(int r);
    logic [95:0] d;
    for (int j = 0; j < 16; j++) d[j*6 +: 6] = locOf(r * 16 + j);
    return d;
  endfunction

  function automatic logic [31:0] vaA(int line);
    return 32'h0001_2000 | (32'(line) << 6);
  endfunction

  function automatic logic [31:0] vaS(int k);
    return 32'h0010_5000 + 32'(k) * 32'h8000;
  endfunction

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic upd(input logic [1:0] op, input logic [31:0] va,
                     input logic [2:0] way, input logic [19:0] ppn,
                     input logic [2:0] perm, input logic [95:0] data,
                     input bit chkReady);
    @(negedge clk);
    updValid = 1'b1; updOp = op; updLineVa = va[31:6];
    updWay = way; updPpn = ppn; updPerm = perm; updData = data;
    #1;
    if (chkReady) chk("R2", 64'(reqReady), 64'd0, "ready during update");
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [3:0] eKind,
                      input logic eL1I, input logic [9:0] eIdx,
                      input logic [3:0] eWay, input logic [31:0] eAddr,
                      input logic [2:0] ePerm, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqVa = va;
    @(negedge clk);
    reqValid = 1'b0;
    chk(req, 64'(rspValid), 64'd1, "rspValid");
    chk(req, 64'(rspKind), 64'(eKind), "rspKind");
    chk(req, 64'(rspL1Instr), 64'(eL1I), "rspL1Instr");
    chk(req, 64'(rspIndex), 64'(eIdx), "rspIndex");
    chk(req, 64'(rspWay), 64'(eWay), "rspWay");
    chk(req, 64'(rspAddr), 64'(eAddr), "rspAddr");
    chk(req, 64'(rspPerm), 64'(ePerm), "rspPerm");
    @(negedge clk);
    chk("R2", 64'(rspValid), 64'd0, "response lasts one cycle");
  endtask

  // hit on page A: expected fields from the bench's own record model
  task automatic lookA(input int line, input logic [3:0] eKind, input string req);
    logic [5:0] l;
    l = model[line];
    case (l[5:4])
      2'b00:   look(vaA(line), eKind, 1'b0, 10'd0, 4'd0,
                    {PPN_A, 6'(line), 6'd0}, PERM_A, req);
      2'b11:   look(vaA(line), eKind, 1'b0, {PPN_A[3:0], 6'(line)}, l[3:0],
                    32'd0, PERM_A, req);
      default: look(vaA(line), eKind, l[5:4] == 2'b01, 10'(line % 32),
                    l[3:0], 32'd0, PERM_A, req);
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = locOf(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", 64'(rspValid), 64'd0, "rspValid after reset");
    chk("R1", 64'(reqReady), 64'd1, "reqReady after reset");
    // R1, R6: empty buffer misses, fill way is lowest free way
    look(vaA(0), K_MISS, 1'b0, 10'd0, 4'd0, vaA(0), 3'd0, "R1");

    // R7: page present, regions not loaded
    upd(2'd0, vaA(0), 3'd5, PPN_A, PERM_A, '0, 1'b1);
    look(vaA(0), K_MISS, 1'b0, 10'd0, 4'd5, vaA(0), 3'd0, "R7");

    // R9: load all four region tables (R2 ready checked on the first)
    for (int r = 0; r < 4; r++)
      upd(2'd2, vaA(r * 16), 3'd5, '0, '0, rgnData(r), r == 0);

    // R3, R4, R5, R11: vector walk
    for (int v = 0; v < 8; v++) begin
      string tag;
      case (VEC[v][3:0])
        K_L1:    tag = "R3";
        K_L2:    tag = "R4";
        default: tag = "R5";
      endcase
      lookA(int'(VEC[v][9:4]), VEC[v][3:0], tag);
    end
    chk("R11", 64'(PERM_A), 64'(3'b101), "perm model");

    // R9: clear region 1, others still usable
    upd(2'd3, vaA(16), 3'd5, '0, '0, '0, 1'b0);
    look(vaA(17), K_MISS, 1'b0, 10'd0, 4'd5, vaA(17), 3'd0, "R9");
    lookA(0, K_MEM, "R9");
    upd(2'd2, vaA(16), 3'd5, '0, '0, rgnData(1), 1'b0);
    lookA(17, K_L1, "R9");

    // R8: single record write
    upd(2'd1, vaA(3), 3'd5, '0, '0, 96'({2'b11, 4'h9}), 1'b0);
    model[3] = {2'b11, 4'h9};
    lookA(3, K_L2, "R8");
    lookA(2, K_L1, "R8");

    // R7: second page in same set, tables not loaded
    upd(2'd0, 32'h0005_2000, 3'd1, 20'h11111, 3'd1, '0, 1'b0);
    look(32'h0005_2000, K_MISS, 1'b0, 10'd0, 4'd1, 32'h0005_2000, 3'd0, "R7");
    lookA(1, K_L1, "R7");

    // R10: fill all ways of set 5 in order 0..7
    for (int k = 0; k < 8; k++)
      upd(2'd0, vaS(k), 3'(k), 20'h200 + 20'(k), 3'b011, '0, 1'b0);
    upd(2'd2, vaS(0), 3'd0, '0, '0, rgnData(0), 1'b0);
    upd(2'd2, vaS(1), 3'd1, '0, '0, rgnData(0), 1'b0);
    look(vaS(8), K_MISS, 1'b0, 10'd0, 4'd0, vaS(8), 3'd0, "R10");
    look(vaS(0) | 32'h40, K_L1, 1'b1, 10'd1, 4'd8, 32'd0, 3'b011, "R10");
    look(vaS(8), K_MISS, 1'b0, 10'd0, 4'd1, vaS(8), 3'd0, "R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule